// File: doc/BRIEF.md
# Segmented Carry-Select Adder/Subtractor

This block adds or subtracts two unsigned/two's-complement operands of parameterised width. The operand bits are cut into fixed-size segments, five bits by default. Inside every segment each bit works out its sum and carry twice: once assuming the segment receives a carry of 0, and once assuming it receives a 1. These two ripple chains run side by side. The true carry arriving from the segment below then picks one of the two precomputed results. As a result, only the segment-to-segment selection lies on the long timing path.

The add/subtract control acts in two places. It inverts operand B, and it sets the carry entering the first bit of the chain, which it reaches by being XORed with the external carry input. No later bit sees it as a carry. In subtract mode the external carry input behaves as a borrow-in.

The chain may begin at any bit position, chosen by a start-offset parameter. Bits below that position copy operand A to the result and play no part in the carry. An optional output stage registers the result, carry-out and overflow flag. That stage has a clock enable, a synchronous clear, and a synchronous load of an alternate value.

Top module: `cs_addsub`

## Requirements
- R1: With `sub`=0, result bits START..WIDTH-1 equal (A + B + `cin`) taken over those bits, modulo 2^(WIDTH-START), with the carry entering at bit START.
- R2: With `sub`=1, result bits START..WIDTH-1 equal (A - B - `cin`) over those bits, modulo 2^(WIDTH-START); `cin`=1 acts as a borrow-in.
- R3: `cout` is the carry out of bit WIDTH-1. For addition it is the unsigned carry. For subtraction it is 1 exactly when no borrow occurs.
- R4: `ovf` is 1 when the carry into bit WIDTH-1 differs from the carry out of it, which is two's-complement overflow.
- R5: Result bits below START equal the matching bits of A. B and `cin` have no effect on them, and the carry enters the chain at bit START.
- R6: With REG_OUT=1, `en`=1, `sclr`=0 and `sload`=0, the outputs show the operation on the inputs present at a rising clock edge, one cycle later.
- R7: With `en`=1 and `sclr`=1, the next edge clears `result`, `cout` and `ovf` to 0. This holds even when `sload`=1.
- R8: With `en`=1, `sclr`=0 and `sload`=1, the next edge loads `load_val` into `result` and clears `cout` and `ovf`.
- R9: With `en`=0, the registered outputs hold their value whatever `sclr`, `sload` and the operands do.
- R10: `rst`=1 at a rising edge clears all registered outputs to 0. It is synchronous and active-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset |
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| sub | input | 1 | 0 = add, 1 = subtract |
| cin | input | 1 | Carry-in (add) or borrow-in (subtract) |
| en | input | 1 | Output stage clock enable |
| sclr | input | 1 | Synchronous clear of the output stage |
| sload | input | 1 | Synchronous load of `load_val` |
| load_val | input | WIDTH | Alternate value for synchronous load |
| result | output | WIDTH | Sum or difference |
| cout | output | 1 | Carry-out / not-borrow |
| ovf | output | 1 | Signed overflow |

## Verification
A fixed table of operand pairs exercises the main function:
- carries that ripple across every segment boundary, such as all-ones plus one;
- signed overflow in both directions for addition and for subtraction;
- borrow against no-borrow;
- the effect of the carry/borrow input.

These cases separate a wrong select polarity, a missing B inversion and a misplaced overflow tap. Random operands are then checked against a behavioural reference on two instances, one starting at bit 0 and one at bit 3. Directed patterns with an all-zero sum and a nonzero carry-in, or with only low-bit B values, show whether the carry truly enters at the start bit and whether the bits below it ignore B.

// File: rtl/cs_addsub_pkg.sv
package cs_addsub_pkg;

  // What the output stage does at the next edge
  typedef enum logic [1:0] {
    OUT_HOLD    = 2'd0,
    OUT_CLEAR   = 2'd1,
    OUT_LOAD    = 2'd2,
    OUT_CAPTURE = 2'd3
  } outsel_e;

  // Number of segments needed to cover a given width
  function automatic int num_segs(input int width, input int seg);
    return (width + seg - 1) / seg;
  endfunction

endpackage

// File: rtl/cs_bitcell.sv
// One bit with two carry chains: one assumes carry 0, the other carry 1.
// A cell below the chain start only passes A and both carries through.
module cs_bitcell #(
  parameter bit ACTIVE = 1'b1
) (
  input  logic a,
  input  logic bx,
  input  logic ci0,
  input  logic ci1,
  output logic s0,
  output logic s1,
  output logic co0,
  output logic co1
);

  generate
    if (ACTIVE) begin : g_act
      logic p;
      assign p   = a ^ bx;
      assign s0  = p ^ ci0;
      assign s1  = p ^ ci1;
      assign co0 = (a & bx) | (ci0 & p);
      assign co1 = (a & bx) | (ci1 & p);
    end else begin : g_pass
      assign s0  = a;
      assign s1  = a;
      assign co0 = ci0;
      assign co1 = ci1;
    end
  endgenerate

endmodule

// File: rtl/cs_segment.sv
// One segment: two ripple chains, then the incoming carry picks one.
module cs_segment #(
  parameter int LEN          = 5,
  parameter int FIRST_ACTIVE = 0
) (
  input  logic [LEN-1:0] a,
  input  logic [LEN-1:0] bx,
  input  logic           cin,
  output logic [LEN-1:0] sum,
  output logic           cout,
  output logic           cmsb
);

  logic [LEN:0]   c0, c1;
  logic [LEN-1:0] s0, s1;

  assign c0[0] = 1'b0;
  assign c1[0] = 1'b1;

  generate
    for (genvar i = 0; i < LEN; i++) begin : g_bit
      cs_bitcell #(.ACTIVE(i >= FIRST_ACTIVE)) u_cell (
        .a   (a[i]),
        .bx  (bx[i]),
        .ci0 (c0[i]),
        .ci1 (c1[i]),
        .s0  (s0[i]),
        .s1  (s1[i]),
        .co0 (c0[i+1]),
        .co1 (c1[i+1])
      );
    end
  endgenerate

  assign sum  = cin ? s1 : s0;
  assign cout = cin ? c1[LEN] : c0[LEN];
  assign cmsb = cin ? c1[LEN-1] : c0[LEN-1];

  // R1: a carry made with carry-in 0 must also be made with carry-in 1
  always_comb begin
    chain_order_chk: assert (!(c0[LEN] && !c1[LEN]));
  end

endmodule

// File: rtl/cs_outstage.sv
// Registered output with enable. Clear beats load, and load beats capture.
module cs_outstage
  import cs_addsub_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         sclr,
  input  logic         sload,
  input  logic [W-1:0] d,
  input  logic         dc,
  input  logic         dv,
  input  logic [W-1:0] ld,
  output logic [W-1:0] q,
  output logic         qc,
  output logic         qv
);

  outsel_e sel;

  always_comb begin
    if (!en)        sel = OUT_HOLD;
    else if (sclr)  sel = OUT_CLEAR;
    else if (sload) sel = OUT_LOAD;
    else            sel = OUT_CAPTURE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q  <= '0;
      qc <= 1'b0;
      qv <= 1'b0;
    end else begin
      unique case (sel)
        OUT_CLEAR: begin
          q  <= '0;
          qc <= 1'b0;
          qv <= 1'b0;
        end
        OUT_LOAD: begin
          q  <= ld;
          qc <= 1'b0;
          qv <= 1'b0;
        end
        OUT_CAPTURE: begin
          q  <= d;
          qc <= dc;
          qv <= dv;
        end
        default: ;
      endcase
    end
  end

  // R7
  clr_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (en && sclr) |=> (q == '0 && !qc && !qv));

  // R8
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !sclr && sload) |=> (q == $past(ld) && !qc && !qv));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> ($stable(q) && $stable(qc) && $stable(qv)));

  // R10
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (q == '0 && !qc && !qv));

endmodule

// File: rtl/cs_addsub.sv
module cs_addsub
  import cs_addsub_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int SEG     = 5,
  parameter int START   = 0,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  input  logic             cin,
  input  logic             en,
  input  logic             sclr,
  input  logic             sload,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] result,
  output logic             cout,
  output logic             ovf
);

  localparam int NSEG = num_segs(WIDTH, SEG);
  localparam int CW   = WIDTH - START;

  logic             c_first;
  logic [WIDTH-1:0] bx;
  logic [WIDTH-1:0] sum_c;
  logic [NSEG:0]    seg_c;
  logic [NSEG-1:0]  seg_msb;
  logic             cout_c, ovf_c;

  // The add/subtract control reaches only the first carry and the B inversion
  assign c_first  = sub ^ cin;
  assign bx       = b ^ {WIDTH{sub}};
  assign seg_c[0] = c_first;

  generate
    for (genvar k = 0; k < NSEG; k++) begin : g_seg
      localparam int LO  = k * SEG;
      localparam int LEN = (LO + SEG <= WIDTH) ? SEG : WIDTH - LO;
      localparam int REL = START - LO;
      localparam int FA  = (REL < 0) ? 0 : ((REL > LEN) ? LEN : REL);

      cs_segment #(.LEN(LEN), .FIRST_ACTIVE(FA)) u_seg (
        .a    (a[LO +: LEN]),
        .bx   (bx[LO +: LEN]),
        .cin  (seg_c[k]),
        .sum  (sum_c[LO +: LEN]),
        .cout (seg_c[k+1]),
        .cmsb (seg_msb[k])
      );
    end
  endgenerate

  assign cout_c = seg_c[NSEG];
  assign ovf_c  = seg_c[NSEG] ^ seg_msb[NSEG-1];

  // Behavioural reference, used only by the assertions
  logic [CW:0] ref_full;
  assign ref_full = {1'b0, a[WIDTH-1:START]} + {1'b0, bx[WIDTH-1:START]}
                  + {{CW{1'b0}}, c_first};

  generate
    if (REG_OUT) begin : g_reg
      cs_outstage #(.W(WIDTH)) u_out (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .sclr  (sclr),
        .sload (sload),
        .d     (sum_c),
        .dc    (cout_c),
        .dv    (ovf_c),
        .ld    (load_val),
        .q     (result),
        .qc    (cout),
        .qv    (ovf)
      );

      // R1 R2 R6
      sum_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !sclr && !sload) |=>
          (result[WIDTH-1:START] == $past(ref_full[CW-1:0])));

      // R3
      cout_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !sclr && !sload) |=> (cout == $past(ref_full[CW])));

      // R4
      ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !sclr && !sload) |=>
          (ovf == $past((a[WIDTH-1] == bx[WIDTH-1]) &&
                        (ref_full[CW-1] != a[WIDTH-1]))));

      if (START > 0) begin : g_low
        // R5
        pass_low_chk: assert property (@(posedge clk) disable iff (rst)
          (en && !sclr && !sload) |=>
            (result[START-1:0] == $past(a[START-1:0])));
      end
    end else begin : g_comb
      assign result = sum_c;
      assign cout   = cout_c;
      assign ovf    = ovf_c;
    end
  endgenerate

endmodule

// File: tb/cs_addsub_tb.sv
module cs_addsub_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a = '0, b = '0, ld = '0;
  logic        sub = 1'b0, cin = 1'b0, en = 1'b1, sclr = 1'b0, sload = 1'b0;
  logic [15:0] r0, r3;
  logic        c0, v0, c3, v3;
  int          total = 0, fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  cs_addsub #(.WIDTH(16), .SEG(5), .START(0), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .a(a), .b(b), .sub(sub), .cin(cin), .en(en),
    .sclr(sclr), .sload(sload), .load_val(ld), .result(r0), .cout(c0), .ovf(v0));

  cs_addsub #(.WIDTH(16), .SEG(5), .START(3), .REG_OUT(1'b1)) u_off (
    .clk(clk), .rst(rst), .a(a), .b(b), .sub(sub), .cin(cin), .en(en),
    .sclr(sclr), .sload(sload), .load_val(ld), .result(r3), .cout(c3), .ovf(v3));

  // Vector layout: {a[51:36], b[35:20], sub[19], cin[18], ovf[17], cout[16], result[15:0]}
  localparam logic [51:0] VEC [0:10] = '{
    {16'h0001, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0002},
    {16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000},
    {16'h7FFF, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b0, 16'h8000},
    {16'h8000, 16'h8000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000},
    {16'h0005, 16'h0003, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0002},
    {16'h0003, 16'h0005, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFE},
    {16'h8000, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b1, 16'h7FFF},
    {16'h1234, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1235},
    {16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF},
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 16'hFFFF},
    {16'h001F, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0020}
  };

  // Reference result {ovf, cout, result} for a chain starting at bit s
  function automatic logic [17:0] ref_op(input logic [15:0] xa, input logic [15:0] xb,
                                         input logic xs, input logic xc, input int s);
    logic [15:0] bb, mhi, ah, bh, res;
    logic [16:0] full;
    logic        ov;
    bb   = xs ? ~xb : xb;
    mhi  = 16'hFFFF << s;
    ah   = xa & mhi;
    bh   = bb & mhi;
    full = {1'b0, ah} + {1'b0, bh} + (17'(xs ^ xc) << s);
    res  = (full[15:0] & mhi) | (xa & ~mhi);
    ov   = (ah[15] == bh[15]) && (full[15] != ah[15]);
    return {ov, full[16], res};
  endfunction

  task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] xa, input logic [15:0] xb,
                       input logic xs, input logic xc);
    a = xa; b = xb; sub = xs; cin = xc;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    // R10: reset clears outputs although inputs are live
    a = 16'hFFFF; b = 16'h0001; en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset dut", {v0, c0, r0}, 18'h0);
    check("R10 reset off", {v3, c3, r3}, 18'h0);
    rst = 1'b0;

    // R1 R2 R3 R4: table walk
    for (int i = 0; i < 11; i++) begin
      apply(VEC[i][51:36], VEC[i][35:20], VEC[i][19], VEC[i][18]);
      check("R1 R2 R3 R4 table", {v0, c0, r0}, VEC[i][17:0]);
      check("R5 R1 R2 table start3", {v3, c3, r3},
            ref_op(VEC[i][51:36], VEC[i][35:20], VEC[i][19], VEC[i][18], 3));
    end

    // R5: carry enters at bit 3; low bits follow A and ignore B
    apply(16'h0000, 16'h0000, 1'b0, 1'b1);
    check("R5 carry at start bit", {v3, c3, r3}, {1'b0, 1'b0, 16'h0008});
    apply(16'h0007, 16'h0007, 1'b0, 1'b0);
    check("R5 low bits ignore B", {v3, c3, r3}, {1'b0, 1'b0, 16'h0007});

    // R1 R2 R3 R4 R5: random operands on both instances
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] ra, rb;
      logic rs, rc;
      ra = 16'($urandom); rb = 16'($urandom); rs = 1'($urandom); rc = 1'($urandom);
      apply(ra, rb, rs, rc);
      check("R1 R2 R3 R4 random", {v0, c0, r0}, ref_op(ra, rb, rs, rc, 0));
      check("R5 random start3", {v3, c3, r3}, ref_op(ra, rb, rs, rc, 3));
    end

    // R6: one-cycle latency
    apply(16'h0100, 16'h0023, 1'b0, 1'b0);
    a = 16'h2000; b = 16'h0002; sub = 1'b1; cin = 1'b0;
    #1;
    check("R6 before edge", {v0, c0, r0}, {1'b0, 1'b0, 16'h0123});
    @(posedge clk); #1;
    check("R6 after edge", {v0, c0, r0}, {1'b0, 1'b1, 16'h1FFE});

    // R9: enable low holds through operand, clear and load changes
    en = 1'b0; sclr = 1'b1; sload = 1'b1; ld = 16'h5A5A;
    apply(16'h1111, 16'h2222, 1'b0, 1'b1);
    check("R9 hold", {v0, c0, r0}, {1'b0, 1'b1, 16'h1FFE});

    // R7: clear wins over load
    en = 1'b1; sclr = 1'b1; sload = 1'b1;
    apply(16'hFFFF, 16'hFFFF, 1'b0, 1'b1);
    check("R7 clear priority", {v0, c0, r0}, 18'h0);

    // R8: load alternate value
    sclr = 1'b0; sload = 1'b1; ld = 16'hA5C3;
    apply(16'h7FFF, 16'h0001, 1'b0, 1'b0);
    check("R8 load", {v0, c0, r0}, {1'b0, 1'b0, 16'hA5C3});
    sload = 1'b0;
    apply(16'h7FFF, 16'h0001, 1'b0, 1'b0);
    check("R4 R8 resume after load", {v0, c0, r0}, {1'b1, 1'b0, 16'h8000});

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule